// File: doc/BRIEF.md
# Nonvolatile Command Sequence Detector

This block watches the access strobes of a static RAM port and picks out a hidden command: six consecutive read accesses to fixed addresses. When the command is found, the block sends a one-cycle request to the controller that moves data between the volatile array and its nonvolatile shadow. The first five addresses form a fixed prefix. The sixth address decides whether the request is a store (volatile to nonvolatile) or a recall (nonvolatile to volatile). Ordinary reads and writes pass through the port unchanged. The detector only observes them.

All inputs are synchronous samples taken in the block clock domain. An access is the cycle in which sampled chip enable falls from high to low. The address and the write-enable level sampled in that cycle classify the access. Any access that does not continue the prefix breaks the match: a write, a read to a different address, or a second chip-enable pulse at the same address. An aborting read of the first prefix address starts a new match at once. While the nonvolatile controller reports busy, detection is held off and the match is cleared.

Top module: `nv_cmd_seq_detect`

## Requirements
- R1: Only address bits 13:0 take part in matching. Address bit 14 has no effect on detection.
- R2: Read accesses to 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F, in that order, followed by a read access to 0x0FC0, raise `store_req_o` for exactly one cycle. The pulse appears in the cycle after the clock edge that samples the sixth chip-enable fall.
- R3: The same five-address prefix followed by a read access to 0x0C63 raises `recall_req_o` for exactly one cycle, with the same timing as R2.
- R4: The prefix followed by a read access to 0x339C produces neither request and clears the match. A following lone read of 0x0FC0 also produces no request.
- R5: An access whose write enable (`we_n_i`, active low) is low at the chip-enable fall aborts the match. It is never taken as a first element.
- R6: If `we_n_i` goes low in any later cycle of the same chip-enable low period, the match is aborted.
- R7: A read access to an address other than the next expected one aborts the match. Each chip-enable fall counts as one access, so a repeated pulse at the same address aborts. Holding chip enable low for several cycles still counts as one access.
- R8: When a read aborts the match and its address is 0x0E38, it is taken as the first element of a new sequence.
- R9: While `busy_i` is high, no request is raised and the match is cleared. A sequence interrupted by busy does not complete.
- R10: After reset both request outputs are low and the match is empty. A sequence split by a reset does not complete.
- R11: `store_req_o` and `recall_req_o` are never high together. Neither stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_n_i | input | 1 | Sampled chip enable, active low; a high-to-low change marks one access |
| we_n_i | input | 1 | Sampled write enable, active low |
| addr_i | input | 15 | Sampled access address |
| busy_i | input | 1 | Nonvolatile cycle in progress; suppresses detection |
| store_req_o | output | 1 | One-cycle store request |
| recall_req_o | output | 1 | One-cycle recall request |

## Verification
Clean store and recall sequences are compared against the reserved tail 0x339C. These patterns show whether the sixth address is actually decoded, rather than any sixth read being accepted. The prefix is also run with bit 14 set, with long chip-enable low periods, and with a duplicated pulse. These patterns separate access counting on edges from counting on levels, and show that the match is confined to the 14 low address bits. Writes at the falling edge and in the middle of a pulse, busy windows, and a reset inside a sequence must each lose the match. An overlapping start (0x0E38, 0x31C7, 0x0E38, …) must still complete through the restart path. A long run of mixed random traffic seeded with prefix addresses is then compared cycle by cycle against a queue-based model.

// File: rtl/nvseq_pkg.sv
`timescale 1ns/1ps
package nvseq_pkg;
  localparam int unsigned MATCH_W    = 14;
  localparam int unsigned PREFIX_LEN = 5;

  typedef logic [MATCH_W-1:0] key_t;

  typedef enum logic [1:0] {
    TAIL_NONE   = 2'd0,
    TAIL_STORE  = 2'd1,
    TAIL_RECALL = 2'd2,
    TAIL_TEST   = 2'd3
  } tail_e;

  localparam key_t STORE_KEY  = 14'h0FC0;
  localparam key_t RECALL_KEY = 14'h0C63;
  localparam key_t TEST_KEY   = 14'h339C;

  // prefix element by position; order is behaviour
  function automatic key_t prefix_key(input int unsigned idx);
    case (idx)
      0:       prefix_key = 14'h0E38;
      1:       prefix_key = 14'h31C7;
      2:       prefix_key = 14'h03E0;
      3:       prefix_key = 14'h3C1F;
      4:       prefix_key = 14'h303F;
      default: prefix_key = '1;
    endcase
  endfunction
endpackage

// File: rtl/nvseq_strobe.sv
`timescale 1ns/1ps
module nvseq_strobe
  import nvseq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_n_i,
  input  logic we_n_i,
  input  key_t key_i,
  output logic acc_o,
  output logic acc_rd_o,
  output key_t acc_key_o,
  output logic hold_wr_o
);
  logic ce_n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ce_n_q <= 1'b1;
    else         ce_n_q <= ce_n_i;
  end

  assign acc_o     = ce_n_q & ~ce_n_i;
  assign acc_rd_o  = we_n_i;
  assign acc_key_o = key_i;
  // write enable dropping inside an already open access
  assign hold_wr_o = ~ce_n_q & ~ce_n_i & ~we_n_i;
endmodule

// File: rtl/nvseq_prefix_match.sv
`timescale 1ns/1ps
module nvseq_prefix_match
  import nvseq_pkg::*;
#(
  parameter int unsigned STEP_W = $clog2(PREFIX_LEN + 1)
) (
  input  key_t              key_i,
  input  logic [STEP_W-1:0] step_i,
  output logic              adv_o,
  output logic              first_o
);
  logic [PREFIX_LEN-1:0] hit;
  logic [PREFIX_LEN-1:0] sel;

  for (genvar g = 0; g < PREFIX_LEN; g++) begin : g_cmp
    assign hit[g] = (key_i == prefix_key(g));
    assign sel[g] = hit[g] & (step_i == STEP_W'(g));
  end

  assign adv_o   = |sel;
  assign first_o = hit[0];
endmodule

// File: rtl/nvseq_tail_decode.sv
`timescale 1ns/1ps
module nvseq_tail_decode
  import nvseq_pkg::*;
(
  input  key_t  key_i,
  output tail_e tail_o
);
  always_comb begin
    unique case (key_i)
      STORE_KEY:  tail_o = TAIL_STORE;
      RECALL_KEY: tail_o = TAIL_RECALL;
      TEST_KEY:   tail_o = TAIL_TEST;
      default:    tail_o = TAIL_NONE;
    endcase
  end
endmodule

// File: rtl/nv_cmd_seq_detect.sv
`timescale 1ns/1ps
module nv_cmd_seq_detect
  import nvseq_pkg::*;
#(
  parameter int unsigned ADDR_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_n_i,
  input  logic              we_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              busy_i,
  output logic              store_req_o,
  output logic              recall_req_o
);
  localparam int unsigned STEP_W = $clog2(PREFIX_LEN + 1);
  localparam logic [STEP_W-1:0] STEP_TAIL = STEP_W'(PREFIX_LEN);

  logic acc, acc_rd, hold_wr, adv, first;
  key_t acc_key;
  tail_e tail;
  logic [STEP_W-1:0] step_q, step_d;
  logic store_q, recall_q, store_d, recall_d;
  logic unused_addr_hi;

  assign unused_addr_hi = ^addr_i[ADDR_W-1:MATCH_W];

  nvseq_strobe u_strobe (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ce_n_i   (ce_n_i),
    .we_n_i   (we_n_i),
    .key_i    (addr_i[MATCH_W-1:0]),
    .acc_o    (acc),
    .acc_rd_o (acc_rd),
    .acc_key_o(acc_key),
    .hold_wr_o(hold_wr)
  );

  nvseq_prefix_match #(.STEP_W(STEP_W)) u_prefix (
    .key_i  (acc_key),
    .step_i (step_q),
    .adv_o  (adv),
    .first_o(first)
  );

  nvseq_tail_decode u_tail (
    .key_i (acc_key),
    .tail_o(tail)
  );

  always_comb begin
    step_d   = step_q;
    store_d  = 1'b0;
    recall_d = 1'b0;
    if (busy_i) begin
      step_d = '0;
    end else if (acc) begin
      if (!acc_rd) begin
        step_d = '0;
      end else if (step_q == STEP_TAIL) begin
        case (tail)
          TAIL_STORE: begin
            store_d = 1'b1;
            step_d  = '0;
          end
          TAIL_RECALL: begin
            recall_d = 1'b1;
            step_d   = '0;
          end
          // reserved test tail and anything else: restart check
          default: step_d = first ? STEP_W'(1) : '0;
        endcase
      end else if (adv) begin
        step_d = step_q + STEP_W'(1);
      end else begin
        step_d = first ? STEP_W'(1) : '0;
      end
    end else if (hold_wr) begin
      step_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q   <= '0;
      store_q  <= 1'b0;
      recall_q <= 1'b0;
    end else begin
      step_q   <= step_d;
      store_q  <= store_d;
      recall_q <= recall_d;
    end
  end

  assign store_req_o  = store_q;
  assign recall_req_o = recall_q;
endmodule

// File: rtl/nvseq_checker.sv
`timescale 1ns/1ps
module nvseq_checker
  import nvseq_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic ce_n_i,
  input logic we_n_i,
  input key_t key_i,
  input logic busy_i,
  input logic store_req_o,
  input logic recall_req_o
);
  assert_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({store_req_o, recall_req_o}));

  assert_store_once_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_req_o |=> !store_req_o);

  assert_recall_once_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recall_req_o |=> !recall_req_o);

  assert_store_tail_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_req_o |-> ($past(key_i) == STORE_KEY) && $past(we_n_i) && !$past(ce_n_i));

  assert_recall_tail_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recall_req_o |-> ($past(key_i) == RECALL_KEY) && $past(we_n_i) && !$past(ce_n_i));

  assert_write_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_n_i && !we_n_i) |=> !(store_req_o || recall_req_o));

  assert_busy_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> !(store_req_o || recall_req_o));
endmodule

bind nv_cmd_seq_detect nvseq_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ce_n_i      (ce_n_i),
  .we_n_i      (we_n_i),
  .key_i       (addr_i[nvseq_pkg::MATCH_W-1:0]),
  .busy_i      (busy_i),
  .store_req_o (store_req_o),
  .recall_req_o(recall_req_o)
);

// File: tb/nv_cmd_seq_detect_tb.sv
`timescale 1ns/1ps
module nv_cmd_seq_detect_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1;
  logic we_n = 1'b1;
  logic [14:0] addr = '0;
  logic busy = 1'b0;
  logic store_o, recall_o;

  int compared = 0;
  int mismatched = 0;
  int st_cnt = 0;
  int rc_cnt = 0;
  string tag = "R10";

  // model state
  int unsigned mq[$];
  bit exp_st = 0, exp_rc = 0, m_ce_prev = 1;
  const int unsigned PRE[5] = '{'h0E38, 'h31C7, 'h03E0, 'h3C1F, 'h303F};

  always #2.5 clk = ~clk;

  nv_cmd_seq_detect u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .ce_n_i      (ce_n),
    .we_n_i      (we_n),
    .addr_i      (addr),
    .busy_i      (busy),
    .store_req_o (store_o),
    .recall_req_o(recall_o)
  );

  task automatic m_restart(input int unsigned k);
    mq.delete();
    if (k == 'h0E38) mq.push_back(k);
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq.delete(); exp_st = 0; exp_rc = 0; m_ce_prev = 1;
    end else begin
      exp_st = 0; exp_rc = 0;
      if (busy) mq.delete();
      else if (m_ce_prev && !ce_n) begin
        if (!we_n) mq.delete();
        else begin
          int unsigned k;
          k = addr & 'h3FFF;
          mq.push_back(k);
          if (mq.size() <= 5) begin
            if (mq[mq.size()-1] != PRE[mq.size()-1]) m_restart(k);
          end else begin
            if (k == 'h0FC0) begin exp_st = 1; mq.delete(); end
            else if (k == 'h0C63) begin exp_rc = 1; mq.delete(); end
            else m_restart(k);
          end
        end
      end else if (!m_ce_prev && !ce_n && !we_n) mq.delete();
      m_ce_prev = ce_n;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      compared++;
      if (store_o !== exp_st || recall_o !== exp_rc) begin
        mismatched++;
        $display("FAIL %s cycle compare: store/recall=%b%b expected %b%b", tag,
                 store_o, recall_o, exp_st, exp_rc);
      end
      if (store_o) st_cnt++;
      if (recall_o) rc_cnt++;
    end
  end

  task automatic acc(input logic [14:0] a, input bit rd = 1, input int low = 1,
                     input int midwr = -1);
    @(negedge clk); ce_n = 0; addr = a; we_n = rd;
    for (int i = 1; i < low; i++) begin
      @(negedge clk);
      if (i == midwr) we_n = 0;
    end
    @(negedge clk); ce_n = 1; we_n = 1;
  endtask

  task automatic prefix(input int n, input bit hi = 0, input int low = 1);
    for (int i = 0; i < n; i++) acc({hi, PRE[i][13:0]}, 1, low);
  endtask

  task automatic prefix_from(input int s);
    for (int i = s; i < 5; i++) acc({1'b0, PRE[i][13:0]});
  endtask

  task automatic begin_phase(input string t);
    repeat (2) @(negedge clk);
    tag = t; st_cnt = 0; rc_cnt = 0;
  endtask

  task automatic end_phase(input int es, input int er);
    repeat (3) @(negedge clk);
    #1;
    compared++;
    if (st_cnt != es || rc_cnt != er) begin
      mismatched++;
      $display("FAIL %s request count: store=%0d recall=%0d expected store=%0d recall=%0d",
               tag, st_cnt, rc_cnt, es, er);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compared++;
    if (store_o !== 1'b0 || recall_o !== 1'b0) begin
      mismatched++;
      $display("FAIL R10 reset outputs: %b%b expected 00", store_o, recall_o);
    end
    rst_n = 1;

    begin_phase("R2");  prefix(5); acc(15'h0FC0); end_phase(1, 0);
    begin_phase("R3");  prefix(5); acc(15'h0C63); end_phase(0, 1);
    begin_phase("R4");  prefix(5); acc(15'h339C); acc(15'h0FC0); end_phase(0, 0);
    begin_phase("R1");  prefix(5, 1); acc(15'h4C63); end_phase(0, 1);
    begin_phase("R5");  prefix(2); acc(15'h03E0, 0); prefix_from(3); acc(15'h0FC0);
                        end_phase(0, 0);
    begin_phase("R6");  prefix(3); acc(15'h3C1F, 1, 3, 1); prefix_from(4); acc(15'h0FC0);
                        end_phase(0, 0);
    begin_phase("R7");  prefix(2); acc(15'h31C7); prefix_from(2); acc(15'h0FC0);
                        end_phase(0, 0);
    begin_phase("R7");  prefix(5, 0, 4); acc(15'h0FC0, 1, 4); end_phase(1, 0);
    begin_phase("R7");  prefix(3); acc(15'h1234); prefix_from(3); acc(15'h0C63);
                        end_phase(0, 0);
    begin_phase("R8");  prefix(2); prefix(5); acc(15'h0C63); end_phase(0, 1);
    begin_phase("R8");  prefix(5); acc(15'h0E38); prefix_from(1); acc(15'h0FC0);
                        end_phase(1, 0);
    begin_phase("R9");  prefix(5); busy = 1; acc(15'h0FC0); busy = 0; acc(15'h0FC0);
                        end_phase(0, 0);
    begin_phase("R9");  prefix(3); @(negedge clk); busy = 1; @(negedge clk); busy = 0;
                        prefix_from(3); acc(15'h0FC0); end_phase(0, 0);
    begin_phase("R10"); prefix(3); @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
                        prefix_from(3); acc(15'h0C63); end_phase(0, 0);
    begin_phase("R2");  prefix(5); acc(15'h0FC0); end_phase(1, 0);

    begin_phase("R11");
    for (int n = 0; n < 3000; n++) begin
      int unsigned r;
      logic [14:0] a;
      r = $urandom % 16;
      if (r < 9) a = {1'($urandom), PRE[r % 5][13:0]};
      else if (r < 11) a = 15'h0FC0;
      else if (r < 13) a = 15'h0C63;
      else if (r == 13) a = 15'h339C;
      else a = 15'($urandom);
      busy = ($urandom % 40 == 0);
      if ($urandom % 8 == 0) acc(a, 0, 1 + $urandom % 2);
      else if ($urandom % 10 == 0) acc(a, 1, 3, 1 + $urandom % 2);
      else acc(a, 1, 1 + $urandom % 3);
      busy = 0;
      if (n % 50 == 0) begin prefix(5); acc(($urandom % 2) ? 15'h0FC0 : 15'h0C63); end
    end
    repeat (4) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule